// File: doc/BRIEF.md
# Bidirectional Memory-Mapped GPIO Port

This block is an 8-pin general-purpose I/O port that sits on a simple CPU bus. The bus has an address, a write strobe, a read strobe, write data and registered read data. Software sets the direction of each pin and the level it drives. Software can also switch off the weak pull device of each pin. The block does not model the pads themselves. For every pin it hands an output level, an output-enable, a pull-enable and a slow-falling-edge enable to pad models outside the block, and it takes each pad's level back in.

Three registers hold the port state. The output latch keeps its contents through reset, so software can set the levels before it turns on any driver. The direction register can be read back. The pull-disable register can only be written. The two upper pins are open-drain: they can pull low or let the line go, and they never drive high. Their slow falling edge is switched on by an input that comes from outside the block. Pin levels pass through a two-flop synchronizer before they reach the read path. They also reach a 5-bit interrupt-source output, which the interrupt controller outside the block samples.

Top module: `gpio_port8`

## Requirements
- R1: While reset is held, and after it is released, the direction and pull-disable registers are 0. In that state every pad_oe bit is 0, pull_en equals ~pull_inhibit, bus_rdata is 0 and irq_src is 0.
- R2: Reset does not change the output latch. A value written to offset 0x00 before a reset is read back, and driven, once the pins are made outputs after the reset.
- R3: A write to offset 0x04 loads the direction register, and a read of 0x04 returns it. A bit value of 1 makes that pin an output and 0 makes it an input.
- R4: For a push-pull pin (pins 0 to 5), pad_out equals its latch bit and pad_oe equals its direction bit. Both take their new values in the cycle after the write edge.
- R5: For an open-drain pin (pins 6 and 7), pad_out is always 0 and pad_oe = direction AND NOT latch bit.
- R6: A read at offset 0x00 returns the latch bit for each output pin and the synchronized pin level for each input pin. bus_rdata is loaded at the clock edge where bus_rd is 1 and keeps its value while bus_rd is 0.
- R7: The pull-disable register at offset 0x10 is written only. A read of 0x10, or of any offset other than 0x00 and 0x04, returns 0.
- R8: pull_en[i] is 1 only when pin i is an input, its pull-disable bit is 0 and pull_inhibit[i] is 0.
- R9: slow_en[6] and slow_en[7] equal slow_ctl AND that pin's direction bit. slow_en[5:0] are always 0.
- R10: irq_src = {pin7, pin3, pin2, pin1, pin0}, where each pin level is taken after the synchronizer. A change on pad_in appears on irq_src after the second rising edge and not after the first.
- R11: A change on an input pin is returned by a read whose bus_rd edge is the third rising edge after the change. A read whose bus_rd edge is the second rising edge after the change still returns the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Level seen at each pad |
| pull_inhibit | input | 8 | Per-pin fixed option that blocks the pull device |
| slow_ctl | input | 1 | Enables the slow falling edge on the open-drain pins |
| pad_out | output | 8 | Output level to the pads |
| pad_oe | output | 8 | Output-enable to the pads |
| pull_en | output | 8 | Pull-device enable to the pads |
| slow_en | output | 8 | Slow-falling-edge enable to the pads |
| irq_src | output | 5 | Synchronized levels of pins 0 to 3 and 7 |

## Verification
The pad controls (pad_out, pad_oe, pull_en, slow_en) are built by logic from the registers only, so they are due in the same cycle as the write edge. The bench drives every write at a falling edge and checks these outputs at the next falling edge. bus_rdata is due one edge after the bus_rd edge. irq_src is due two edges after a pad_in change, and a read of a pin level needs a third edge. The bench checks each of these results one edge early as well as on time, so a missing or extra stage shows up as a miscompare.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register offsets decoded on the bus
  localparam int unsigned OFF_LATCH = 32'h00;
  localparam int unsigned OFF_DIR   = 32'h04;
  localparam int unsigned OFF_PULL  = 32'h10;

  // Number of set bits of mask below bit position idx
  function automatic int unsigned bits_below(input logic [31:0] mask, input int unsigned idx);
    int unsigned n;
    n = 0;
    for (int unsigned k = 0; k < idx; k++) begin
      if (mask[k]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = din;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign dout = stage_q[STAGES-1];

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_chk
      // R10
      sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q[g] == $past(stage_q[g-1]));
    end
  endgenerate

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic [PORT_W-1:0] pin_sync,
  output logic [PORT_W-1:0] bus_rdata,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] pull_q
);
  import gpio_port_pkg::*;

  logic              sel_latch, sel_dir, sel_pull;
  logic              we_latch, we_dir, we_pull;
  logic [PORT_W-1:0] dir_d, pull_d, rdata_d;

  always_comb begin
    sel_latch = (bus_addr == ADDR_W'(OFF_LATCH));
    sel_dir   = (bus_addr == ADDR_W'(OFF_DIR));
    sel_pull  = (bus_addr == ADDR_W'(OFF_PULL));
    we_latch  = bus_wr & sel_latch;
    we_dir    = bus_wr & sel_dir;
    we_pull   = bus_wr & sel_pull;
  end

  always_comb begin
    dir_d  = we_dir  ? bus_wdata : dir_q;
    pull_d = we_pull ? bus_wdata : pull_q;
    if (sel_latch)    rdata_d = (dir_q & latch_q) | (~dir_q & pin_sync);
    else if (sel_dir) rdata_d = dir_q;
    else              rdata_d = '0;
  end

  // Output latch: no reset, by intent
  always_ff @(posedge clk) begin
    if (we_latch) latch_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      pull_q <= '0;
    end else begin
      dir_q  <= dir_d;
      pull_q <= pull_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_d;
  end

  // R3
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_DIR)) |=> dir_q == $past(bus_wdata));

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R7
  rdata_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != ADDR_W'(OFF_LATCH) && bus_addr != ADDR_W'(OFF_DIR))
      |=> bus_rdata == '0);

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int unsigned         PORT_W    = 8,
  parameter logic [PORT_W-1:0]   OD_MASK   = 8'hC0,
  parameter logic [PORT_W-1:0]   SLOW_MASK = 8'hC0
) (
  input  logic [PORT_W-1:0] latch_q,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] pull_q,
  input  logic [PORT_W-1:0] pull_inhibit,
  input  logic              slow_ctl,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pull_en,
  output logic [PORT_W-1:0] slow_en
);

  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      if (OD_MASK[i]) begin : g_od
        assign pad_out[i] = 1'b0;
        assign pad_oe[i]  = dir_q[i] & ~latch_q[i];
      end else begin : g_pp
        assign pad_out[i] = latch_q[i];
        assign pad_oe[i]  = dir_q[i];
      end
      if (SLOW_MASK[i]) begin : g_slow
        assign slow_en[i] = slow_ctl & dir_q[i];
      end else begin : g_fast
        assign slow_en[i] = 1'b0;
      end
      assign pull_en[i] = ~dir_q[i] & ~pull_q[i] & ~pull_inhibit[i];
    end
  endgenerate

endmodule

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int unsigned       PORT_W      = 8,
  parameter int unsigned       ADDR_W      = 5,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [PORT_W-1:0] OD_MASK     = 8'hC0,
  parameter logic [PORT_W-1:0] SLOW_MASK   = 8'hC0,
  parameter logic [PORT_W-1:0] IRQ_MASK    = 8'h8F,
  parameter int unsigned       IRQ_W       = gpio_port_pkg::bits_below(32'(IRQ_MASK), PORT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pad_in,
  input  logic [PORT_W-1:0] pull_inhibit,
  input  logic              slow_ctl,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pull_en,
  output logic [PORT_W-1:0] slow_en,
  output logic [IRQ_W-1:0]  irq_src
);

  logic [PORT_W-1:0] pin_sync, latch_q, dir_q, pull_q;

  gpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pad_in),
    .dout (pin_sync)
  );

  gpio_regs #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .pin_sync (pin_sync),
    .bus_rdata(bus_rdata),
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .pull_q   (pull_q)
  );

  gpio_pad_ctl #(.PORT_W(PORT_W), .OD_MASK(OD_MASK), .SLOW_MASK(SLOW_MASK)) u_pad (
    .latch_q     (latch_q),
    .dir_q       (dir_q),
    .pull_q      (pull_q),
    .pull_inhibit(pull_inhibit),
    .slow_ctl    (slow_ctl),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pull_en     (pull_en),
    .slow_en     (slow_en)
  );

  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_irq
      if (IRQ_MASK[i]) begin : g_tap
        localparam int unsigned POS = gpio_port_pkg::bits_below(32'(IRQ_MASK), i);
        assign irq_src[POS] = pin_sync[i];
      end
    end
  endgenerate

  // R8
  pull_vs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en & dir_q) == '0);

  // R4
  oe_vs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q) == '0);

  // R5
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & OD_MASK) == '0);

endmodule

// File: tb/tb_gpio_port8.sv
module tb_gpio_port8;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam logic [4:0] A_LATCH = 5'h00;
  localparam logic [4:0] A_DIR   = 5'h04;
  localparam logic [4:0] A_PULL  = 5'h10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] pad_in, pull_inhibit;
  logic       slow_ctl;
  logic [7:0] pad_out, pad_oe, pull_en, slow_en;
  logic [4:0] irq_src;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port8 dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pull_inhibit(pull_inhibit), .slow_ctl(slow_ctl), .pad_out(pad_out),
    .pad_oe(pad_oe), .pull_en(pull_en), .slow_en(slow_en), .irq_src(irq_src)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [4:0] irq_of(input logic [7:0] p);
    return {p[7], p[3:0]};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, v, pl, inh, pin, old_pin;
    logic       sl;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    pad_in = 8'h5A; pull_inhibit = 8'h0F; slow_ctl = 1'b1;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 pad_oe in reset", pad_oe, 8'h00);
    check("R1 pull_en in reset", pull_en, 8'hF0);
    check("R1 slow_en in reset", slow_en, 8'h00);
    check("R1 rdata in reset", bus_rdata, 8'h00);
    check("R1 irq_src in reset", {3'b0, irq_src}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pad_oe after reset", pad_oe, 8'h00);
    check("R1 pull_en after reset", pull_en, 8'hF0);
    bus_read(A_DIR, rd);
    check("R1 dir readback after reset", rd, 8'h00);

    // R2: latch survives reset
    bus_write(A_LATCH, 8'h96);
    bus_write(A_DIR, 8'hFF);
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 pad_oe cleared by reset", pad_oe, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    bus_write(A_DIR, 8'hFF);
    check("R2 pad_out keeps latch", pad_out, 8'h16);
    check("R2 pad_oe open-drain from kept latch", pad_oe, 8'h7F);
    bus_read(A_LATCH, rd);
    check("R2 latch readback after reset", rd, 8'h96);

    // Sweep over all direction values
    for (int d = 0; d < 256; d++) begin
      v   = 8'(d * 37 + 11);
      pl  = 8'((d << 1) | (d >> 7));
      inh = 8'((d << 4) | (d >> 4));
      pin = 8'(d * 113 + 7);
      sl  = d[0] ^ d[3];
      pad_in = pin; pull_inhibit = inh; slow_ctl = sl;
      bus_write(A_PULL, pl);
      bus_write(A_DIR, 8'(d));
      bus_write(A_LATCH, v);
      // R4
      check("R4 pad_out push-pull", pad_out & 8'h3F, v & 8'h3F);
      check("R4 pad_oe push-pull", pad_oe & 8'h3F, 8'(d) & 8'h3F);
      // R5
      check("R5 pad_out open-drain", pad_out & 8'hC0, 8'h00);
      check("R5 pad_oe open-drain", pad_oe & 8'hC0, 8'(d) & ~v & 8'hC0);
      // R8
      check("R8 pull_en", pull_en, ~8'(d) & ~pl & ~inh);
      // R9
      check("R9 slow_en", slow_en, sl ? (8'(d) & 8'hC0) : 8'h00);
      // R3
      bus_read(A_DIR, rd);
      check("R3 dir readback", rd, 8'(d));
      // R6
      bus_read(A_LATCH, rd);
      check("R6 mixed readback", rd, (8'(d) & v) | (~8'(d) & pin));
      // R7
      bus_read(A_PULL, rd);
      check("R7 pull read is zero", rd, 8'h00);
      // R6 hold: writes with no read leave bus_rdata alone
      bus_read(A_DIR, rd);
      bus_write(A_DIR, ~8'(d));
      check("R6 rdata held without read", bus_rdata, 8'(d));
    end

    // R7: every offset other than 0x00 and 0x04 reads 0
    bus_write(A_DIR, 8'hFF);
    bus_write(A_LATCH, 8'hFF);
    for (int a = 0; a < 32; a++) begin
      if (a != 0 && a != 4) begin
        bus_read(5'(a), rd);
        check("R7 unmapped offset reads zero", rd, 8'h00);
      end
    end

    // R10: irq_src latency and mapping over all pin values
    old_pin = pad_in;
    for (int p = 0; p < 256; p++) begin
      pad_in = 8'(p);
      @(negedge clk);
      check("R10 irq_src one edge early", {3'b0, irq_src}, {3'b0, irq_of(old_pin)});
      @(negedge clk);
      check("R10 irq_src after two edges", {3'b0, irq_src}, {3'b0, irq_of(8'(p))});
      old_pin = 8'(p);
    end

    // R11: read latency of an input pin
    bus_write(A_DIR, 8'h00);
    for (int p = 0; p < 256; p += 17) begin
      pad_in = 8'(p) ^ 8'hFF;
      repeat (3) @(negedge clk);
      pad_in = 8'(p);
      @(negedge clk);
      bus_read(A_LATCH, rd);
      check("R11 read at second edge is old", rd, 8'(p) ^ 8'hFF);
      pad_in = 8'(p) ^ 8'hFF;
      @(negedge clk);
      pad_in = 8'(p) ^ 8'hFF;
      repeat (2) @(negedge clk);
      pad_in = 8'(p);
      repeat (2) @(negedge clk);
      bus_read(A_LATCH, rd);
      check("R11 read at third edge is new", rd, 8'(p));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule